// File: doc/BRIEF.md
# Dual-Issue Slot Steering Unit

The unit sits between decode and two integer pipes. Each cycle it is offered up to two decoded instructions, an older one on input 0 and a younger one on input 1, each carrying a 4-bit operation class and, for block transfers, a word count. It decides which of the two issue slots each instruction takes and which pipe (0 or 1) it is sent to. Each pipe has an execute, memory and writeback stage. Some classes are tied to one slot or one pipe, some claim both slots, and some hold their pipe's execute stage for several cycles. The unit keeps a small occupancy counter per pipe and holds issue back while the stage an instruction needs is still busy.

Issue is strictly in order. If the older instruction cannot go, nothing goes. If only the older one fits, the younger one is reported as waiting, and upstream presents it again in the next cycle. A per-pipe counter is loaded with the hold time minus one when an instruction enters. The pipe accepts a new instruction only when that counter reads zero. Class codes: 0 plain ALU (also used for misc, MMU and DSP ALU), 1 shift-ALU, 2 sum-of-absolute-differences, 3 64-bit move, 4 load, 5 post-update load, 6 store, 7 register-offset store, 8 load/store multiple, 9 multiply, 10 MAC, 11 divide, 12 divide-with-remainder, 13 branch, 14 pipe-0 DSP op, 15 wide DSP op (64-bit DSP ALU, DSP MAC, word extract).

Top module: `steer_top`

## Requirements
- R1: Synchronous active-high reset clears both occupancy counters. The first cycle after reset, with no valid input, drives every output low, and two class-0 instructions then issue together: older on slot 0 / pipe 0, younger on slot 1 / pipe 1.
- R2: Classes 0, 1 and 2 may use either slot and either pipe. The older one takes slot 1 only if the younger is slot-0-bound, and prefers pipe 1 only if the younger is pipe-0-bound; otherwise it takes slot 0 and pipe 0 when free. The two issued instructions never share a pipe.
- R3: Class 3 issues only from slot 1, on either pipe.
- R4: Classes 4, 5, 6, 7 and 8 issue only from slot 1 and only to pipe 1.
- R5: Classes 9, 10, 11, 12, 13, 14 and 15 issue from slot 0 to pipe 0.
- R6: Classes 5, 7, 10, 12 and 15 claim both slots. They raise dual_claim, issue alone and only as the older instruction, and a younger one of these classes always waits.
- R7: Class 1 holds its pipe's execute stage for 2 cycles and class 2 for 3 cycles; all classes not otherwise listed hold it for 1 cycle.
- R8: Class 8 holds pipe 1 for min(N,4) cycles, where N is the word count; N=0 counts as 1.
- R9: Classes 9 and 10 hold pipe 0 for 1, 2 or 4 cycles for mul_cfg 0, 1, 2 (3 acts as 2). Classes 11 and 12 hold it for 4 cycles.
- R10: The younger instruction never issues unless the older one issues in the same cycle.
- R11: An instruction issues only to a pipe whose execute stage is free in that cycle; otherwise it waits.
- R12: wait_old / wait_yng are high exactly when the matching input is valid and is not issued that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mul_cfg | input | 2 | Multiplier speed: 0 one cycle, 1 two, 2/3 four |
| in0_vld | input | 1 | Older instruction present |
| in0_cls | input | 4 | Older instruction class code |
| in0_words | input | 4 | Older instruction transfer word count |
| in1_vld | input | 1 | Younger instruction present |
| in1_cls | input | 4 | Younger instruction class code |
| in1_words | input | 4 | Younger instruction transfer word count |
| iss_old | output | 1 | Older instruction issued this cycle |
| iss_yng | output | 1 | Younger instruction issued this cycle |
| s0_vld | output | 1 | Slot 0 carries an instruction |
| s0_pipe | output | 1 | Pipe chosen for slot 0 |
| s0_yng | output | 1 | Slot 0 carries the younger instruction |
| s1_vld | output | 1 | Slot 1 carries an instruction |
| s1_pipe | output | 1 | Pipe chosen for slot 1 |
| s1_yng | output | 1 | Slot 1 carries the younger instruction |
| dual_claim | output | 1 | Issued instruction claims both slots |
| wait_old | output | 1 | Older instruction held back |
| wait_yng | output | 1 | Younger instruction held back |

## Verification
The embedded properties check, on every cycle, the rules that need no history: program order between the two issues, distinct pipes, the slot and pipe binding of load/store and pipe-0 classes and of the 64-bit move, a both-slot instruction going out alone, and that a pipe never accepts work while its counter is non-zero. The exact stall lengths cannot be seen in one cycle. These are the 2- and 3-cycle ALU holds, the transfer-count hold with its cap and zero case, and the multiplier configurations. So are the slot and pipe preferences that let a pair go out together. Only the bench's directed sequences and its cycle-accurate reference model, run over random traffic, show them.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int CLS_W    = 4;
  localparam int WORDS_W  = 4;
  localparam int NPIPE    = 2;
  localparam int LSM_CAP  = 4;
  localparam int MAX_HOLD = 4;
  localparam int HOLD_W   = $clog2(MAX_HOLD + 1);
  localparam int OCC_W    = $clog2(MAX_HOLD);

  typedef enum logic [CLS_W-1:0] {
    C_ALU      = 4'd0,
    C_SHIFT    = 4'd1,
    C_SAD      = 4'd2,
    C_MOV64    = 4'd3,
    C_LD       = 4'd4,
    C_LD_UPD   = 4'd5,
    C_ST       = 4'd6,
    C_ST_RIDX  = 4'd7,
    C_LSM      = 4'd8,
    C_MUL      = 4'd9,
    C_MAC      = 4'd10,
    C_DIV      = 4'd11,
    C_DIVREM   = 4'd12,
    C_BR       = 4'd13,
    C_DSP      = 4'd14,
    C_DSP_WIDE = 4'd15
  } op_cls_e;

  typedef enum logic [1:0] {SL_ANY = 2'd0, SL_0 = 2'd1, SL_1 = 2'd2} slot_rule_e;
  typedef enum logic [1:0] {PR_ANY = 2'd0, PR_0 = 2'd1, PR_1 = 2'd2} pipe_rule_e;

  typedef struct packed {
    slot_rule_e              slot;
    pipe_rule_e              pipe;
    logic                    both;
    logic [HOLD_W-1:0]       hold;
  } cls_info_t;

  // Execute-stage cycles for multiply/MAC by multiplier speed
  function automatic logic [HOLD_W-1:0] mul_hold(input logic [1:0] cfg);
    case (cfg)
      2'd0:    return HOLD_W'(1);
      2'd1:    return HOLD_W'(2);
      default: return HOLD_W'(4);
    endcase
  endfunction

  // Execute-stage cycles for a block transfer of n words
  function automatic logic [HOLD_W-1:0] lsm_hold(input logic [WORDS_W-1:0] n);
    if (n == '0)                   return HOLD_W'(1);
    else if (int'(n) >= LSM_CAP)   return HOLD_W'(LSM_CAP);
    else                           return HOLD_W'(n);
  endfunction
endpackage

// File: rtl/steer_cls_decode.sv
module steer_cls_decode
  import steer_pkg::*;
(
  input  logic [CLS_W-1:0]   cls,
  input  logic [WORDS_W-1:0] words,
  input  logic [1:0]         mul_cfg,
  output cls_info_t          info
);
  always_comb begin
    info.slot = SL_ANY;
    info.pipe = PR_ANY;
    info.both = 1'b0;
    info.hold = HOLD_W'(1);
    case (op_cls_e'(cls))
      C_ALU:      ;
      C_SHIFT:    info.hold = HOLD_W'(2);
      C_SAD:      info.hold = HOLD_W'(3);
      C_MOV64:    info.slot = SL_1;
      C_LD, C_ST: begin info.slot = SL_1; info.pipe = PR_1; end
      C_LD_UPD, C_ST_RIDX: begin
        info.slot = SL_1; info.pipe = PR_1; info.both = 1'b1;
      end
      C_LSM: begin
        info.slot = SL_1; info.pipe = PR_1; info.hold = lsm_hold(words);
      end
      C_MUL: begin
        info.slot = SL_0; info.pipe = PR_0; info.hold = mul_hold(mul_cfg);
      end
      C_MAC: begin
        info.slot = SL_0; info.pipe = PR_0; info.both = 1'b1;
        info.hold = mul_hold(mul_cfg);
      end
      C_DIV: begin
        info.slot = SL_0; info.pipe = PR_0; info.hold = HOLD_W'(4);
      end
      C_DIVREM: begin
        info.slot = SL_0; info.pipe = PR_0; info.both = 1'b1;
        info.hold = HOLD_W'(4);
      end
      C_BR, C_DSP: begin info.slot = SL_0; info.pipe = PR_0; end
      C_DSP_WIDE: begin
        info.slot = SL_0; info.pipe = PR_0; info.both = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/steer_pipe_occ.sv
module steer_pipe_occ
  import steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [HOLD_W-1:0] hold,
  output logic              free
);
  logic [OCC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (issue)          left_q <= OCC_W'(hold - 1'b1);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign free = (left_q == '0);

  // R11: work enters only an idle execute stage
  a_r11_enter_idle: assert property (@(posedge clk) disable iff (rst)
    issue |-> left_q == '0);
  // R7: a multi-cycle hold keeps the stage busy next cycle
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (issue && hold > HOLD_W'(1)) |=> !free);
  // R7: a single-cycle hold leaves the stage free next cycle
  a_r7_single_free: assert property (@(posedge clk) disable iff (rst)
    (issue && hold == HOLD_W'(1)) |=> free);
endmodule

// File: rtl/steer_pick.sv
module steer_pick
  import steer_pkg::*;
(
  input  logic                          v0,
  input  logic                          v1,
  input  cls_info_t                     info0,
  input  cls_info_t                     info1,
  input  logic [NPIPE-1:0]              free,
  output logic                          iss_old,
  output logic                          iss_yng,
  output logic [1:0]                    s_vld,
  output logic [1:0]                    s_pipe,
  output logic [1:0]                    s_yng,
  output logic                          dual,
  output logic [NPIPE-1:0]              go,
  output logic [NPIPE-1:0][HOLD_W-1:0]  go_hold
);
  logic b_plain, pref_s1, want_p;
  logic a_ok, a_slot, a_pipe;
  logic b_ok, b_slot, b_pipe, b_slot_ok, b_pipe_ok;

  always_comb begin
    iss_old = 1'b0; iss_yng = 1'b0; dual = 1'b0;
    s_vld = '0; s_pipe = '0; s_yng = '0; go = '0; go_hold = '0;
    b_plain = v1 && !info1.both;
    pref_s1 = b_plain && (info1.slot == SL_0);
    want_p  = b_plain && (info1.pipe == PR_0);
    a_ok = 1'b0; a_slot = 1'b0; a_pipe = 1'b0;
    if (v0) begin
      if (info0.both) begin
        a_pipe = (info0.pipe == PR_1);
        a_slot = a_pipe;
        a_ok   = free[a_pipe];
      end else begin
        a_slot = (info0.slot == SL_ANY) ? pref_s1 : (info0.slot == SL_1);
        case (info0.pipe)
          PR_0: begin a_pipe = 1'b0; a_ok = free[0]; end
          PR_1: begin a_pipe = 1'b1; a_ok = free[1]; end
          default: begin
            if (free[want_p])       begin a_pipe = want_p;  a_ok = 1'b1; end
            else if (free[!want_p]) begin a_pipe = !want_p; a_ok = 1'b1; end
          end
        endcase
      end
    end
    if (a_ok) begin
      iss_old          = 1'b1;
      s_vld[a_slot]    = 1'b1;
      s_pipe[a_slot]   = a_pipe;
      go[a_pipe]       = 1'b1;
      go_hold[a_pipe]  = info0.hold;
      dual             = info0.both;
    end
    b_slot    = !a_slot;
    b_pipe    = !a_pipe;
    b_slot_ok = (info1.slot == SL_ANY) || (info1.slot == (b_slot ? SL_1 : SL_0));
    b_pipe_ok = (info1.pipe == PR_ANY) || (info1.pipe == (b_pipe ? PR_1 : PR_0));
    b_ok      = a_ok && !info0.both && b_plain && b_slot_ok && b_pipe_ok && free[b_pipe];
    if (b_ok) begin
      iss_yng          = 1'b1;
      s_vld[b_slot]    = 1'b1;
      s_pipe[b_slot]   = b_pipe;
      s_yng[b_slot]    = 1'b1;
      go[b_pipe]       = 1'b1;
      go_hold[b_pipe]  = info1.hold;
    end
  end
endmodule

// File: rtl/steer_top.sv
module steer_top
  import steer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mul_cfg,
  input  logic               in0_vld,
  input  logic [CLS_W-1:0]   in0_cls,
  input  logic [WORDS_W-1:0] in0_words,
  input  logic               in1_vld,
  input  logic [CLS_W-1:0]   in1_cls,
  input  logic [WORDS_W-1:0] in1_words,
  output logic               iss_old,
  output logic               iss_yng,
  output logic               s0_vld,
  output logic               s0_pipe,
  output logic               s0_yng,
  output logic               s1_vld,
  output logic               s1_pipe,
  output logic               s1_yng,
  output logic               dual_claim,
  output logic               wait_old,
  output logic               wait_yng
);
  logic [1:0][CLS_W-1:0]   cls_a;
  logic [1:0][WORDS_W-1:0] words_a;
  cls_info_t               info_a [2];
  logic [NPIPE-1:0]        pipe_free;
  logic [NPIPE-1:0]        pipe_go;
  logic [NPIPE-1:0][HOLD_W-1:0] pipe_hold;
  logic [1:0] s_vld, s_pipe, s_yng;

  assign cls_a   = {in1_cls, in0_cls};
  assign words_a = {in1_words, in0_words};

  for (genvar i = 0; i < 2; i++) begin : g_dec
    steer_cls_decode u_dec (
      .cls     (cls_a[i]),
      .words   (words_a[i]),
      .mul_cfg (mul_cfg),
      .info    (info_a[i])
    );
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_occ
    steer_pipe_occ u_occ (
      .clk   (clk),
      .rst   (rst),
      .issue (pipe_go[p]),
      .hold  (pipe_hold[p]),
      .free  (pipe_free[p])
    );
  end

  steer_pick u_pick (
    .v0      (in0_vld),
    .v1      (in1_vld),
    .info0   (info_a[0]),
    .info1   (info_a[1]),
    .free    (pipe_free),
    .iss_old (iss_old),
    .iss_yng (iss_yng),
    .s_vld   (s_vld),
    .s_pipe  (s_pipe),
    .s_yng   (s_yng),
    .dual    (dual_claim),
    .go      (pipe_go),
    .go_hold (pipe_hold)
  );

  assign s0_vld   = s_vld[0];
  assign s1_vld   = s_vld[1];
  assign s0_pipe  = s_pipe[0];
  assign s1_pipe  = s_pipe[1];
  assign s0_yng   = s_yng[0];
  assign s1_yng   = s_yng[1];
  assign wait_old = in0_vld && !iss_old;
  assign wait_yng = in1_vld && !iss_yng;

  // R10: younger never overtakes older
  a_r10_in_order: assert property (@(posedge clk) disable iff (rst)
    iss_yng |-> iss_old);
  // R2: one pipe per instruction per cycle
  a_r2_distinct_pipes: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && s1_vld) |-> (s0_pipe != s1_pipe));
  // R6: both-slot instruction goes alone
  a_r6_alone: assert property (@(posedge clk) disable iff (rst)
    dual_claim |-> (!iss_yng && !(s0_vld && s1_vld)));
  // R6: a younger both-slot instruction never issues
  a_r6_yng_never: assert property (@(posedge clk) disable iff (rst)
    (in1_vld && (op_cls_e'(in1_cls) inside {C_LD_UPD, C_ST_RIDX, C_MAC, C_DIVREM, C_DSP_WIDE}))
      |-> !iss_yng);
  // R4: memory classes sit in slot 1 on pipe 1
  a_r4_mem_slot1: assert property (@(posedge clk) disable iff (rst)
    (iss_old && (op_cls_e'(in0_cls) inside {C_LD, C_LD_UPD, C_ST, C_ST_RIDX, C_LSM}))
      |-> (s1_vld && !s1_yng && s1_pipe));
  // R5: pipe-0 classes sit in slot 0 on pipe 0
  a_r5_p0_slot0: assert property (@(posedge clk) disable iff (rst)
    (iss_old && (op_cls_e'(in0_cls) inside {C_MUL, C_MAC, C_DIV, C_DIVREM, C_BR, C_DSP, C_DSP_WIDE}))
      |-> (s0_vld && !s0_yng && !s0_pipe));
  // R3: wide move only from slot 1
  a_r3_mov_slot1: assert property (@(posedge clk) disable iff (rst)
    (iss_yng && op_cls_e'(in1_cls) == C_MOV64) |-> (s1_vld && s1_yng));
endmodule

// File: tb/tb_steer_top.sv
module tb_steer_top;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] mul_cfg;
  logic in0_vld, in1_vld;
  logic [3:0] in0_cls, in1_cls, in0_words, in1_words;
  logic iss_old, iss_yng, s0_vld, s0_pipe, s0_yng, s1_vld, s1_pipe, s1_yng;
  logic dual_claim, wait_old, wait_yng;

  int n_vec = 0;
  int n_bad = 0;
  int busy [2];

  always #4 clk = ~clk;

  steer_top dut (
    .clk(clk), .rst(rst), .mul_cfg(mul_cfg),
    .in0_vld(in0_vld), .in0_cls(in0_cls), .in0_words(in0_words),
    .in1_vld(in1_vld), .in1_cls(in1_cls), .in1_words(in1_words),
    .iss_old(iss_old), .iss_yng(iss_yng),
    .s0_vld(s0_vld), .s0_pipe(s0_pipe), .s0_yng(s0_yng),
    .s1_vld(s1_vld), .s1_pipe(s1_pipe), .s1_yng(s1_yng),
    .dual_claim(dual_claim), .wait_old(wait_old), .wait_yng(wait_yng)
  );

  // 0 = slot 0 only, 1 = slot 1 only, 2 = either
  function automatic int slot_of(int c);
    if (c >= 3 && c <= 8) return 1;
    if (c >= 9) return 0;
    return 2;
  endfunction
  function automatic int pipe_of(int c);
    if (c >= 4 && c <= 8) return 1;
    if (c >= 9) return 0;
    return 2;
  endfunction
  function automatic bit dual_of(int c);
    return c == 5 || c == 7 || c == 10 || c == 12 || c == 15;
  endfunction
  function automatic int hold_of(int c, int w, int cfg);
    case (c)
      1: return 2;
      2: return 3;
      8: return (w == 0) ? 1 : ((w > 4) ? 4 : w);
      9, 10: return (cfg == 0) ? 1 : ((cfg == 1) ? 2 : 4);
      11, 12: return 4;
      default: return 1;
    endcase
  endfunction

  // reference model: expected outputs and next occupancy
  task automatic model(output logic [10:0] e);
    bit io = 0, iy = 0, dl = 0;
    bit [1:0] sv = 0, sp = 0, sy = 0;
    int h [2];
    int c0 = in0_cls, c1 = in1_cls;
    h[0] = 0; h[1] = 0;
    if (in0_vld) begin
      int as = 0, ap = -1;
      if (dual_of(c0)) begin
        int p = pipe_of(c0);
        if (busy[p] == 0) begin ap = p; as = p; dl = 1; end
      end else begin
        bit yp = in1_vld && !dual_of(c1);
        int wp = (yp && pipe_of(c1) == 0) ? 1 : 0;
        as = (slot_of(c0) == 2) ? ((yp && slot_of(c1) == 0) ? 1 : 0) : slot_of(c0);
        if (pipe_of(c0) == 2) begin
          if (busy[wp] == 0) ap = wp;
          else if (busy[1-wp] == 0) ap = 1 - wp;
        end else if (busy[pipe_of(c0)] == 0) ap = pipe_of(c0);
      end
      if (ap >= 0) begin
        io = 1; sv[as] = 1; sp[as] = ap[0];
        h[ap] = hold_of(c0, in0_words, mul_cfg);
        if (in1_vld && !dl && !dual_of(c1)) begin
          int bs = 1 - as, bp = 1 - ap;
          if ((slot_of(c1) == 2 || slot_of(c1) == bs) &&
              (pipe_of(c1) == 2 || pipe_of(c1) == bp) && busy[bp] == 0) begin
            iy = 1; sv[bs] = 1; sp[bs] = bp[0]; sy[bs] = 1;
            h[bp] = hold_of(c1, in1_words, mul_cfg);
          end
        end
      end
    end
    e = {io, iy, sv[0], sp[0], sy[0], sv[1], sp[1], sy[1], dl,
         in0_vld && !io, in1_vld && !iy};
    for (int p = 0; p < 2; p++)
      busy[p] = (h[p] > 0) ? h[p] - 1 : ((busy[p] > 0) ? busy[p] - 1 : 0);
  endtask

  task automatic step(input bit v0, input int c0, input int w0,
                      input bit v1, input int c1, input int w1,
                      input int cfg, input string tag);
    logic [10:0] exp_v, act;
    @(negedge clk);
    in0_vld = v0; in0_cls = 4'(c0); in0_words = 4'(w0);
    in1_vld = v1; in1_cls = 4'(c1); in1_words = 4'(w1);
    mul_cfg = 2'(cfg);
    #1;
    model(exp_v);
    act = {iss_old, iss_yng, s0_vld, s0_pipe, s0_yng, s1_vld, s1_pipe, s1_yng,
           dual_claim, wait_old, wait_yng};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cls=%0d/%0d act=%b exp=%b", tag, c0, c1, act, exp_v);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; in0_vld = 0; in1_vld = 0; in0_cls = 0; in1_cls = 0;
    in0_words = 0; in1_words = 0; mul_cfg = 0;
    busy[0] = 0; busy[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: idle outputs, then a full pair
    step(0,0,0, 0,0,0, 0, "R1");
    step(1,0,0, 1,0,0, 0, "R1");
    // R3: wide move
    step(1,0,0, 1,3,0, 0, "R3");
    step(1,3,0, 1,9,0, 0, "R3");
    step(1,3,0, 1,4,0, 0, "R3");
    // R4: memory classes
    step(1,4,0, 1,0,0, 0, "R4");
    step(1,0,0, 1,6,0, 0, "R4");
    step(1,8,2, 1,4,0, 0, "R4");
    step(0,0,0, 0,0,0, 0, "R4");
    // R5: pipe-0 classes
    step(1,13,0, 1,9,0, 0, "R5");
    step(1,14,0, 1,4,0, 0, "R5");
    // R2: any-class adapts to a slot-0 partner
    step(1,0,0, 1,13,0, 0, "R2");
    step(1,1,0, 1,6,0, 0, "R2");
    step(0,0,0, 0,0,0, 0, "R2");
    // R6: both-slot classes
    step(1,10,0, 1,0,0, 0, "R6");
    step(1,0,0, 1,5,0, 0, "R6");
    step(1,5,0, 1,0,0, 0, "R6");
    step(1,15,0, 0,0,0, 0, "R6");
    // R7: shift and SAD holds
    step(1,1,0, 0,0,0, 0, "R7");
    repeat (2) step(1,13,0, 0,0,0, 0, "R7");
    step(1,2,0, 1,4,0, 0, "R7");
    repeat (3) step(1,11,0, 0,0,0, 0, "R7");
    repeat (4) step(0,0,0, 0,0,0, 0, "R7");
    // R8: transfer count hold, cap and zero
    step(1,8,7, 0,0,0, 0, "R8");
    repeat (5) step(1,4,0, 0,0,0, 0, "R8");
    step(1,8,0, 0,0,0, 0, "R8");
    repeat (2) step(1,6,0, 0,0,0, 0, "R8");
    step(1,8,3, 0,0,0, 0, "R8");
    repeat (3) step(1,4,0, 0,0,0, 0, "R8");
    // R9: multiplier configurations and divide
    step(1,9,0, 0,0,0, 2, "R9");
    repeat (4) step(1,9,0, 0,0,0, 1, "R9");
    step(1,10,0, 0,0,0, 0, "R9");
    step(1,13,0, 0,0,0, 3, "R9");
    step(1,12,0, 0,0,0, 0, "R9");
    repeat (4) step(1,13,0, 1,0,0, 0, "R9");
    // R10 R11 R12: random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      bit v0 = ($urandom % 8) != 0;
      bit v1 = v0 && (($urandom % 4) != 0);
      step(v0, $urandom % 16, $urandom % 16, v1, $urandom % 16, $urandom % 16,
           $urandom % 4, "R10 R11 R12");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule